// File: doc/BRIEF.md
# Privilege-Mode Memory Access Guard

This block sits between a CPU's memory bus and the peripheral select logic of a small secure controller. It decodes each bus access by the top byte of the address, looks up which region that byte names, and then decides whether the current execution mode may perform that access. Allowed accesses assert exactly one region select and let the peripheral's ready and read data through. Denied accesses assert no select. One cycle later the block itself completes the access with ready high, read data forced to zero and a one-cycle violation pulse, so the CPU never stalls on a blocked access.

There are three execution modes. Firmware mode has the widest rights. System-call mode runs the trap handler that an application enters through the interrupt-trigger area. Application mode has the fewest rights. Execute-from-ROM, the firmware scratch RAM, a serial-flash window inside the control region, and writes to a parameterised list of secret-bearing control registers depend on the mode. The block also produces the firmware-RAM enable and combines it with a separately supplied enable before any access reaches the RAM banks.

Top module: `priv_access_guard`

## Requirements
- R1: A valid access selects by address bits [31:24]. The select bit index for each prefix is: bit0 0x00 boot ROM, bit1 0x40 main RAM, bit2 0xc0 entropy source, bit3 0xc1 timer, bit4 0xc2 secret store, bit5 0xc3 serial port, bit6 0xc4 touch sensor, bit7 0xd0 firmware RAM, bit8 0xe1 interrupt-trigger area, bit9 0xff control registers. At most one select bit is high, and only while the access is valid and allowed.
- R2: The mode input is encoded 2'b00 firmware, 2'b01 system call and 2'b10 application. The value 2'b11 behaves exactly like application.
- R3: The boot ROM can be read in every mode. An instruction fetch from it is denied in application mode. Any write to it (non-zero byte strobes) is denied in every mode.
- R4: In application mode, the firmware RAM and the serial-flash window are denied for reads, writes and fetches. The window covers control-region word offsets (address bits [9:2]) 0x40 to 0x47. In the other two modes both are open for reading and writing.
- R5: Writes to the sensitive control-region word offsets 0x0c, 0x0d, 0x10, 0x11, 0x18, 0x19, 0x20, 0x27, 0x30 and 0x3f are allowed only in firmware mode. Reads of these offsets are allowed in every mode.
- R6: The firmware-RAM enable output is high in firmware and system-call modes. The firmware-RAM go output equals the firmware-RAM select ANDed with the external enable input.
- R7: An access whose prefix is not in the R1 list is denied in every mode.
- R8: The cycle after a denied access is presented, ready is high, read data is zero and violation is high. The violation pulse lasts exactly one cycle.
- R9: For an allowed access, ready and read data are passed through from the peripheral response, and violation stays low.
- R10: After reset, ready and violation are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Bus access request, held until ready |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wstrb | input | 4 | Byte write strobes; zero means read |
| cpu_instr | input | 1 | Access is an instruction fetch |
| exec_mode | input | 2 | Current execution mode (R2 encoding) |
| fwram_en_i | input | 1 | External enable for the firmware RAM |
| periph_ready | input | 1 | Ready from the selected peripheral |
| periph_rdata | input | 32 | Read data from the selected peripheral |
| region_sel | output | 10 | One-hot region selects (R1 bit order) |
| fwram_en | output | 1 | Mode permits firmware RAM |
| fwram_go | output | 1 | Firmware RAM select gated by external enable |
| cpu_ready | output | 1 | Ready returned to the CPU |
| cpu_rdata | output | 32 | Read data returned to the CPU |
| violation | output | 1 | One-cycle pulse for a denied access |

## Verification
The bench goes after the cases where a permission table is easy to get subtly wrong. It sweeps all 256 prefixes in every mode with reads, writes and fetches. A decoder with a wrong or missing prefix either raises a select for unmapped space or denies a live region. It also sweeps every control-region word offset in every mode with reads and writes. A misplaced flash window or sensitive list then either lets an application or trap handler modify secrets or blocks firmware. Mode 2'b11 is swept like the others, so a design that treated it as firmware would open the firmware RAM to applications. Every denial is checked for a zeroed, completed response and a violation that drops after one cycle. A design that passed peripheral data through or held the pulse would leak data or hang the CPU.

// File: rtl/guard_pkg.sv
package guard_pkg;

    localparam int NUM_REGIONS = 10;
    localparam int PFX_W       = 8;
    localparam int OFF_W       = 8;

    localparam int RG_ROM    = 0;
    localparam int RG_RAM    = 1;
    localparam int RG_ENT    = 2;
    localparam int RG_TIMER  = 3;
    localparam int RG_SECRET = 4;
    localparam int RG_SERIAL = 5;
    localparam int RG_TOUCH  = 6;
    localparam int RG_FWRAM  = 7;
    localparam int RG_TRAP   = 8;
    localparam int RG_CTRL   = 9;

    typedef enum logic [1:0] {
        MODE_FW      = 2'b00,
        MODE_SYS     = 2'b01,
        MODE_APP     = 2'b10,
        MODE_APP_ALT = 2'b11
    } exec_mode_e;

    typedef struct packed {
        logic fw;
        logic sys;
        logic app;
    } mode_flags_t;

    typedef struct packed {
        logic deny;
    } guard_state_t;

    function automatic logic [PFX_W-1:0] region_prefix(input int idx);
        logic [PFX_W-1:0] p;
        case (idx)
            RG_ROM:    p = 8'h00;
            RG_RAM:    p = 8'h40;
            RG_ENT:    p = 8'hc0;
            RG_TIMER:  p = 8'hc1;
            RG_SECRET: p = 8'hc2;
            RG_SERIAL: p = 8'hc3;
            RG_TOUCH:  p = 8'hc4;
            RG_FWRAM:  p = 8'hd0;
            RG_TRAP:   p = 8'he1;
            default:   p = 8'hff;
        endcase
        return p;
    endfunction

    function automatic mode_flags_t decode_mode(input logic [1:0] m);
        mode_flags_t f;
        f.fw  = (m == MODE_FW);
        f.sys = (m == MODE_SYS);
        f.app = m[1];
        return f;
    endfunction

endpackage

// File: rtl/guard_region_decode.sv
module guard_region_decode
    import guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]      addr,
    output logic [NUM_REGIONS-1:0] hit
);
    localparam int PFX_LSB = ADDR_W - PFX_W;

    logic [PFX_W-1:0] pfx;
    assign pfx = addr[PFX_LSB +: PFX_W];

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_cmp
        assign hit[i] = (pfx == region_prefix(i));
    end

endmodule

// File: rtl/guard_offset_match.sv
module guard_offset_match
    import guard_pkg::*;
#(
    parameter int                      SENS_NUM  = 10,
    parameter logic [SENS_NUM*OFF_W-1:0] SENS_LIST = '0,
    parameter logic [OFF_W-1:0]        SPI_LO    = 8'h40,
    parameter logic [OFF_W-1:0]        SPI_HI    = 8'h47
) (
    input  logic [OFF_W-1:0] offset,
    output logic             sens_hit,
    output logic             spi_hit
);
    logic [SENS_NUM-1:0] match_vec;

    for (genvar k = 0; k < SENS_NUM; k++) begin : g_sens
        assign match_vec[k] = (offset == SENS_LIST[k*OFF_W +: OFF_W]);
    end

    assign sens_hit = |match_vec;
    assign spi_hit  = (offset >= SPI_LO) && (offset <= SPI_HI);

endmodule

// File: rtl/guard_policy.sv
module guard_policy
    import guard_pkg::*;
(
    input  mode_flags_t            mode,
    input  logic                   is_write,
    input  logic                   is_fetch,
    input  logic                   sens_hit,
    input  logic                   spi_hit,
    output logic [NUM_REGIONS-1:0] perm
);
    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_perm
        if (i == RG_ROM) begin : g_rom
            // Read-only everywhere; no execute in application mode.
            assign perm[i] = !is_write && !(mode.app && is_fetch);
        end else if (i == RG_FWRAM) begin : g_fwram
            assign perm[i] = !mode.app;
        end else if (i == RG_CTRL) begin : g_ctrl
            // Flash window invisible to applications; secrets firmware-write only.
            assign perm[i] = !(mode.app && spi_hit) &&
                             !(sens_hit && is_write && !mode.fw);
        end else begin : g_open
            assign perm[i] = 1'b1;
        end
    end

endmodule

// File: rtl/priv_access_guard.sv
module priv_access_guard
    import guard_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int STRB_W   = DATA_W / 8,
    parameter int OFF_LSB  = 2,
    parameter int SENS_NUM = 10,
    parameter logic [SENS_NUM*OFF_W-1:0] SENS_LIST = {
        8'h3f, 8'h30, 8'h27, 8'h20, 8'h19,
        8'h18, 8'h11, 8'h10, 8'h0d, 8'h0c},
    parameter logic [OFF_W-1:0] SPI_LO = 8'h40,
    parameter logic [OFF_W-1:0] SPI_HI = 8'h47
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_valid,
    input  logic [ADDR_W-1:0]      cpu_addr,
    input  logic [STRB_W-1:0]      cpu_wstrb,
    input  logic                   cpu_instr,
    input  logic [1:0]             exec_mode,
    input  logic                   fwram_en_i,
    input  logic                   periph_ready,
    input  logic [DATA_W-1:0]      periph_rdata,
    output logic [NUM_REGIONS-1:0] region_sel,
    output logic                   fwram_en,
    output logic                   fwram_go,
    output logic                   cpu_ready,
    output logic [DATA_W-1:0]      cpu_rdata,
    output logic                   violation
);
    logic [NUM_REGIONS-1:0] hit;
    logic [NUM_REGIONS-1:0] perm;
    logic [NUM_REGIONS-1:0] granted;
    logic                   sens_hit;
    logic                   spi_hit;
    logic                   allow_any;
    mode_flags_t            mflags;
    guard_state_t           st_d;
    guard_state_t           st_q;

    logic unused_addr_bits;
    assign unused_addr_bits = ^{cpu_addr[ADDR_W-PFX_W-1:OFF_LSB+OFF_W],
                                cpu_addr[OFF_LSB-1:0]};

    assign mflags = decode_mode(exec_mode);

    guard_region_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (cpu_addr),
        .hit  (hit)
    );

    guard_offset_match #(
        .SENS_NUM  (SENS_NUM),
        .SENS_LIST (SENS_LIST),
        .SPI_LO    (SPI_LO),
        .SPI_HI    (SPI_HI)
    ) u_off (
        .offset   (cpu_addr[OFF_LSB +: OFF_W]),
        .sens_hit (sens_hit),
        .spi_hit  (spi_hit)
    );

    guard_policy u_pol (
        .mode     (mflags),
        .is_write (|cpu_wstrb),
        .is_fetch (cpu_instr),
        .sens_hit (sens_hit),
        .spi_hit  (spi_hit),
        .perm     (perm)
    );

    assign granted   = hit & perm;
    assign allow_any = |granted;

    always_comb begin
        st_d      = st_q;
        st_d.deny = cpu_valid && !allow_any && !st_q.deny;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign region_sel = cpu_valid ? granted : '0;
    assign fwram_en   = !mflags.app;
    assign fwram_go   = region_sel[RG_FWRAM] && fwram_en_i;
    assign violation  = st_q.deny;
    assign cpu_ready  = st_q.deny ? 1'b1 : periph_ready;
    assign cpu_rdata  = st_q.deny ? '0 : periph_rdata;

endmodule

// File: rtl/guard_checker.sv
module guard_checker
    import guard_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cpu_valid,
    input logic [1:0]             exec_mode,
    input logic                   fwram_en_i,
    input logic [NUM_REGIONS-1:0] region_sel,
    input logic                   fwram_en,
    input logic                   fwram_go,
    input logic                   cpu_ready,
    input logic [DATA_W-1:0]      cpu_rdata,
    input logic                   violation
);
    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(region_sel) && (cpu_valid || region_sel == '0));

    assert_app_no_fwram_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exec_mode[1] |-> (!region_sel[RG_FWRAM] && !fwram_en));

    assert_fwram_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fwram_go |-> (region_sel[RG_FWRAM] && fwram_en_i && fwram_en));

    assert_deny_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> (cpu_ready && cpu_rdata == '0));

    assert_deny_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> !violation);

    assert_deny_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && region_sel == '0 && !violation) |=> violation);

    assert_no_viol_on_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && region_sel != '0) |=> !violation);

endmodule

bind priv_access_guard guard_checker #(.DATA_W(DATA_W)) u_guard_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .exec_mode  (exec_mode),
    .fwram_en_i (fwram_en_i),
    .region_sel (region_sel),
    .fwram_en   (fwram_en),
    .fwram_go   (fwram_go),
    .cpu_ready  (cpu_ready),
    .cpu_rdata  (cpu_rdata),
    .violation  (violation)
);

// File: tb/priv_access_guard_test.sv
`timescale 1ns/1ps
module priv_access_guard_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [3:0]  cpu_wstrb = '0;
    logic        cpu_instr = 1'b0;
    logic [1:0]  exec_mode = 2'b00;
    logic        fwram_en_i = 1'b0;
    logic        periph_ready = 1'b0;
    logic [31:0] periph_rdata = '0;
    logic [9:0]  region_sel;
    logic        fwram_en;
    logic        fwram_go;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        violation;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    priv_access_guard uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_valid    (cpu_valid),
        .cpu_addr     (cpu_addr),
        .cpu_wstrb    (cpu_wstrb),
        .cpu_instr    (cpu_instr),
        .exec_mode    (exec_mode),
        .fwram_en_i   (fwram_en_i),
        .periph_ready (periph_ready),
        .periph_rdata (periph_rdata),
        .region_sel   (region_sel),
        .fwram_en     (fwram_en),
        .fwram_go     (fwram_go),
        .cpu_ready    (cpu_ready),
        .cpu_rdata    (cpu_rdata),
        .violation    (violation)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Region index from prefix per R1, -1 when unmapped (R7).
    function automatic int region_of(input logic [7:0] p);
        case (p)
            8'h00: return 0;
            8'h40: return 1;
            8'hc0: return 2;
            8'hc1: return 3;
            8'hc2: return 4;
            8'hc3: return 5;
            8'hc4: return 6;
            8'hd0: return 7;
            8'he1: return 8;
            8'hff: return 9;
            default: return -1;
        endcase
    endfunction

    function automatic bit is_sens(input logic [7:0] o);
        return o == 8'h0c || o == 8'h0d || o == 8'h10 || o == 8'h11 ||
               o == 8'h18 || o == 8'h19 || o == 8'h20 || o == 8'h27 ||
               o == 8'h30 || o == 8'h3f;
    endfunction

    // op: 0 read, 1 write, 2 fetch. Returns requirement tag of the deciding rule.
    function automatic string decide(input logic [1:0] m, input logic [7:0] p,
                                     input logic [7:0] o, input int op,
                                     output bit allow);
        bit app = m[1];
        bit fw  = (m == 2'b00);
        int r   = region_of(p);
        allow = 1'b1;
        if (r < 0) begin allow = 1'b0; return "R7"; end
        if (r == 0) begin
            allow = !(op == 1) && !(app && op == 2);
            return "R3";
        end
        if (r == 7) begin allow = !app; return "R4"; end
        if (r == 9) begin
            if (app && o >= 8'h40 && o <= 8'h47) begin allow = 1'b0; return "R4"; end
            if (is_sens(o) && op == 1 && !fw) begin allow = 1'b0; return "R5"; end
            if (is_sens(o)) return "R5";
        end
        if (m == 2'b11) return "R2";
        return "R1";
    endfunction

    task automatic access(input logic [1:0] m, input logic [7:0] p,
                          input logic [7:0] o, input int op, input bit fen);
        bit allow;
        string tag;
        int r;
        logic [9:0] exp_sel;
        logic [31:0] pat;
        tag = decide(m, p, o, op, allow);
        r = region_of(p);
        exp_sel = (allow && r >= 0) ? (10'd1 << r) : 10'd0;
        pat = {p, o, 6'd0, m, 8'h5a};
        @(negedge clk);
        cpu_valid    = 1'b1;
        cpu_addr     = {p, 14'd0, o, 2'b00};
        cpu_wstrb    = (op == 1) ? 4'hf : 4'h0;
        cpu_instr    = (op == 2);
        exec_mode    = m;
        fwram_en_i   = fen;
        periph_ready = 1'b0;
        periph_rdata = 32'hdead_beef;
        #1;
        check(region_sel == exp_sel, tag, "region_sel", {22'd0, region_sel}, {22'd0, exp_sel});
        check(fwram_en == !m[1], "R6", "fwram_en", {31'd0, fwram_en}, {31'd0, !m[1]});
        check(fwram_go == (exp_sel[7] && fen), "R6", "fwram_go",
              {31'd0, fwram_go}, {31'd0, exp_sel[7] && fen});
        @(negedge clk);
        if (!allow) begin
            check(violation == 1'b1, "R8", "violation", {31'd0, violation}, 32'd1);
            check(cpu_ready == 1'b1, "R8", "cpu_ready", {31'd0, cpu_ready}, 32'd1);
            check(cpu_rdata == 32'd0, "R8", "cpu_rdata", cpu_rdata, 32'd0);
            cpu_valid = 1'b0;
            @(negedge clk);
            check(violation == 1'b0, "R8", "violation pulse width", {31'd0, violation}, 32'd0);
        end else begin
            check(violation == 1'b0, "R9", "violation", {31'd0, violation}, 32'd0);
            check(cpu_ready == 1'b0, "R9", "cpu_ready idle", {31'd0, cpu_ready}, 32'd0);
            periph_ready = 1'b1;
            periph_rdata = pat;
            #1;
            check(cpu_ready == 1'b1, "R9", "cpu_ready pass", {31'd0, cpu_ready}, 32'd1);
            check(cpu_rdata == pat, "R9", "cpu_rdata pass", cpu_rdata, pat);
            @(negedge clk);
            cpu_valid    = 1'b0;
            periph_ready = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(cpu_ready == 1'b0, "R10", "cpu_ready in reset", {31'd0, cpu_ready}, 32'd0);
        check(violation == 1'b0, "R10", "violation in reset", {31'd0, violation}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(violation == 1'b0, "R10", "violation after reset", {31'd0, violation}, 32'd0);
        check(region_sel == 10'd0, "R1", "idle select", {22'd0, region_sel}, 32'd0);

        // Prefix sweep: every prefix, mode (incl. 2'b11 per R2) and operation.
        for (int m = 0; m < 4; m++)
            for (int p = 0; p < 256; p++)
                for (int op = 0; op < 3; op++)
                    access(2'(m), 8'(p), 8'h01, op, ((p ^ m ^ op) & 1) == 1);

        // Control-region offset sweep: flash window (R4) and secrets (R5).
        for (int m = 0; m < 4; m++)
            for (int o = 0; o < 256; o++)
                for (int op = 0; op < 2; op++)
                    access(2'(m), 8'hff, 8'(o), op, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule